// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a fully associative address translation cache with 64 entries, shared by instruction and data accesses. Software alone decides what the array holds. Each entry has a tag word and a data word. The tag word holds an effective page number, a 3-bit page-size code and a valid flag. The data word holds a real page number, execute and write permissions, a 4-bit zone select and four cache attribute bits. The size code sets how many low address bits an entry ignores in the compare. It also sets how many of those bits pass straight through to the physical address. Pages from 1 KB to 16 MB can therefore sit side by side in one array.

Software drives a single operation port. A 3-bit operation code selects one of: idle, read a word, write a word, search by address, invalidate by address, or invalidate everything. A word select bit chooses the tag word or the data word. The lookup port is purely combinational from the stored entries. It returns the hit flag, a multi-hit flag, the winning index, the physical address, the permissions, the zone select and the attributes.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and `sw_rdata`, `sw_found` and `sw_fidx` are zero.
- R2: Operation codes are 0 idle, 1 read, 2 write, 3 search, 4 invalidate-by-address and 5 invalidate-all. `sw_sel`=0 addresses the tag word and `sw_sel`=1 addresses the data word of entry `sw_idx`. A read result appears on `sw_rdata` one cycle after the operation and holds until the next read.
- R3: Tag word layout is: effective page number in bits 31:10, size code in bits 9:7, valid flag in bit 6. Bits 5:0 are not stored and read back as zero. The data word is stored and read back in full.
- R4: Size code s (0 to 7) selects a page of 1K, 4K, 16K, 64K, 256K, 1M, 4M or 16M. The low 10+2*s address bits are left out of the compare. A lookup hits only on a valid entry whose remaining page-number bits equal those of the address.
- R5: On a hit, the physical address takes the entry's real page number (data bits 31:10) above the page offset. It takes the lookup address bits below the page offset. Page-number bits that fall inside the offset are ignored in both the tag and the data word.
- R6: On a hit, `lk_exec`, `lk_wr`, `lk_zone` and `lk_attr` come from data bits 9, 8, 7:4 and 3:0. The attribute order is write-through, cache-inhibited, coherent, guarded from bit 3 down to bit 0. On a miss, all lookup data outputs are zero.
- R7: When several valid entries match, the lowest index wins and `lk_multi` is raised.
- R8: A search with address `sw_wdata` sets `sw_found` and `sw_fidx` (the lowest matching index, zero when none) one cycle later. It leaves every entry unchanged.
- R9: Invalidate-by-address with address `sw_wdata` clears the valid bit of every entry that address matches. The page number and size code of those entries are kept, and other entries are untouched.
- R10: Invalidate-all clears the valid bit of every entry, so every lookup from the next cycle misses.
- R11: A write takes effect at the clock edge that ends its cycle. Lookups see it from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_op | input | 3 | Software operation code |
| sw_sel | input | 1 | Word select: 0 tag, 1 data |
| sw_idx | input | 6 | Entry index for read and write |
| sw_wdata | input | 32 | Write data, or address for search and invalidate |
| sw_rdata | output | 32 | Read result |
| sw_found | output | 1 | Search found a match |
| sw_fidx | output | 6 | Index found by search |
| lk_va | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one entry matched |
| lk_idx | output | 6 | Winning entry index |
| lk_pa | output | 32 | Translated physical address |
| lk_exec | output | 1 | Execute allowed |
| lk_wr | output | 1 | Write allowed |
| lk_zone | output | 4 | Zone select |
| lk_attr | output | 4 | Cache attributes |

## Verification
The assertions check on every cycle the invariants that need no knowledge of the contents. These are: multi-hit implies hit, the low offset passes through, a miss gives quiet outputs, a hit lands on a valid entry, search leaves the valid bits alone, read data holds between reads, and both invalidations take effect on the following lookup. The mixing of page sizes can only be shown by the bench scenarios. Those scenarios cover the correct mask width for each size code, masked-off page bits in the stored words, the priority between overlapping small and large pages, and the exact field positions on readback.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 10;
    localparam int EPN_W  = VA_W - OFF_W;
    localparam int SZ_W   = 3;
    localparam int TAG_W  = EPN_W + SZ_W + 1;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_SRCH = 3'd3,
        OP_INV1 = 3'd4,
        OP_INVA = 3'd5
    } sw_op_e;

    // Page-number compare mask: each size step widens the offset by two bits
    function automatic logic [EPN_W-1:0] pg_mask(input logic [SZ_W-1:0] sz);
        return {EPN_W{1'b1}} << (2 * sz);
    endfunction
endpackage

// File: rtl/vpt_cam_cmp.sv
module vpt_cam_cmp
    import vpt_pkg::*;
#(
    parameter int N_ENT = 64
) (
    input  logic [N_ENT-1:0][TAG_W-1:0] tags,
    input  logic [EPN_W-1:0]            va_pn,
    output logic [N_ENT-1:0]            hit_vec
);
    // stored tag: [TAG_W-1:SZ_W+1] page number, [SZ_W:1] size, [0] valid
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        assign hit_vec[gi] = tags[gi][0] &&
            (((tags[gi][TAG_W-1:SZ_W+1] ^ va_pn) & pg_mask(tags[gi][SZ_W:1])) == '0);
    end
endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] req,
    output logic             any,
    output logic             multi,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any   = |req;
        multi = |(req & (req - {{(N_ENT-1){1'b0}}, 1'b1}));
    end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sw_op,
    input  logic             sw_sel,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [VA_W-1:0]  sw_wdata,
    output logic [VA_W-1:0]  sw_rdata,
    output logic             sw_found,
    output logic [IDX_W-1:0] sw_fidx,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic             lk_multi,
    output logic [IDX_W-1:0] lk_idx,
    output logic [VA_W-1:0]  lk_pa,
    output logic             lk_exec,
    output logic             lk_wr,
    output logic [3:0]       lk_zone,
    output logic [3:0]       lk_attr
);
    typedef struct packed {
        logic [N_ENT-1:0][TAG_W-1:0] tag;
        logic [N_ENT-1:0][VA_W-1:0]  dat;
        logic [VA_W-1:0]             rdata;
        logic                        found;
        logic [IDX_W-1:0]            fidx;
    } st_t;

    st_t d, q;
    sw_op_e op;
    assign op = sw_op_e'(sw_op);

    // associative compare: lookup side and software side
    logic [N_ENT-1:0] l_vec, s_vec;
    logic             l_any, l_multi, s_any, s_multi;
    logic [IDX_W-1:0] l_idx, s_idx;

    vpt_cam_cmp #(.N_ENT(N_ENT)) u_cmp_lk (
        .tags(q.tag), .va_pn(lk_va[VA_W-1:OFF_W]), .hit_vec(l_vec));
    vpt_cam_cmp #(.N_ENT(N_ENT)) u_cmp_sw (
        .tags(q.tag), .va_pn(sw_wdata[VA_W-1:OFF_W]), .hit_vec(s_vec));
    vpt_prio #(.N_ENT(N_ENT)) u_pri_lk (
        .req(l_vec), .any(l_any), .multi(l_multi), .idx(l_idx));
    vpt_prio #(.N_ENT(N_ENT)) u_pri_sw (
        .req(s_vec), .any(s_any), .multi(s_multi), .idx(s_idx));

    // valid flags, exposed for the checker
    logic [N_ENT-1:0] vld_vec;
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_vld
        assign vld_vec[gi] = q.tag[gi][0];
    end

    always_comb begin
        d = q;
        unique case (op)
            OP_RD:   d.rdata = sw_sel ? q.dat[sw_idx]
                                      : {q.tag[sw_idx], {(VA_W-TAG_W){1'b0}}};
            OP_WR: begin
                if (sw_sel) d.dat[sw_idx] = sw_wdata;
                else        d.tag[sw_idx] = sw_wdata[VA_W-1:VA_W-TAG_W];
            end
            OP_SRCH: begin
                d.found = s_any;
                d.fidx  = s_any ? s_idx : '0;
            end
            OP_INV1: begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (s_vec[i]) d.tag[i][0] = 1'b0;
                end
            end
            OP_INVA: begin
                for (int i = 0; i < N_ENT; i++) d.tag[i][0] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // lookup result merge
    logic [SZ_W-1:0]  l_sz;
    logic [VA_W-1:0]  l_dat;
    logic [EPN_W-1:0] l_msk;

    always_comb begin
        l_sz  = q.tag[l_idx][SZ_W:1];
        l_dat = q.dat[l_idx];
        l_msk = pg_mask(l_sz);
        lk_hit   = l_any;
        lk_multi = l_multi;
        lk_idx   = l_any ? l_idx : '0;
        lk_pa    = '0;
        lk_exec  = 1'b0;
        lk_wr    = 1'b0;
        lk_zone  = '0;
        lk_attr  = '0;
        if (l_any) begin
            lk_pa   = {(l_dat[VA_W-1:OFF_W] & l_msk) | (lk_va[VA_W-1:OFF_W] & ~l_msk),
                       lk_va[OFF_W-1:0]};
            lk_exec = l_dat[9];
            lk_wr   = l_dat[8];
            lk_zone = l_dat[7:4];
            lk_attr = l_dat[3:0];
        end
    end

    assign sw_rdata = q.rdata;
    assign sw_found = q.found;
    assign sw_fidx  = q.fidx;

    logic unused_s_multi;
    assign unused_s_multi = s_multi;
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk
    import vpt_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sw_op,
    input logic [VA_W-1:0]  sw_wdata,
    input logic [VA_W-1:0]  sw_rdata,
    input logic [VA_W-1:0]  lk_va,
    input logic             lk_hit,
    input logic             lk_multi,
    input logic [IDX_W-1:0] lk_idx,
    input logic [VA_W-1:0]  lk_pa,
    input logic             lk_exec,
    input logic             lk_wr,
    input logic [3:0]       lk_zone,
    input logic [3:0]       lk_attr,
    input logic [N_ENT-1:0] vld_vec
);
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);                                               // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));                 // R5
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && !lk_exec && !lk_wr && lk_zone == '0 && lk_attr == '0)); // R6
    AST_HIT_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> vld_vec[lk_idx]);                                        // R4
    AST_SEARCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op == OP_SRCH) |=> (vld_vec == $past(vld_vec)));                // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op != OP_RD) |=> $stable(sw_rdata));                            // R2
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op == OP_INVA) |=> !lk_hit);                                    // R10
    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op == OP_INV1) ##1 (lk_va == $past(sw_wdata)) |-> !lk_hit);     // R9
endmodule

bind vpt_tlb vpt_tlb_chk #(.N_ENT(N_ENT)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .lk_va(lk_va), .lk_hit(lk_hit), .lk_multi(lk_multi),
    .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_exec(lk_exec), .lk_wr(lk_wr),
    .lk_zone(lk_zone), .lk_attr(lk_attr), .vld_vec(vld_vec));

// File: tb/vpt_tlb_tb.sv
`timescale 1ns/1ps
module vpt_tlb_tb;
    import vpt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sw_op = 3'd0;
    logic        sw_sel = 1'b0;
    logic [5:0]  sw_idx = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        sw_found;
    logic [5:0]  sw_fidx;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_multi, lk_exec, lk_wr;
    logic [5:0]  lk_idx;
    logic [31:0] lk_pa;
    logic [3:0]  lk_zone, lk_attr;

    always #2.5 clk = ~clk;

    vpt_tlb u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit          is_srch;
        logic [31:0] exp_rd;
        logic        exp_f;
        logic [5:0]  exp_i;
        string       req;
    } item_t;
    item_t exp_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per clock edge that follows a response op
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                #1;
                if (it.is_srch) begin
                    check(sw_found === it.exp_f, it.req, 32'(sw_found), 32'(it.exp_f));
                    check(sw_fidx === it.exp_i, it.req, 32'(sw_fidx), 32'(it.exp_i));
                end else begin
                    check(sw_rdata === it.exp_rd, it.req, sw_rdata, it.exp_rd);
                end
            end
        end
    end

    task automatic drive(input logic [2:0] op, input logic sel, input logic [5:0] idx, input logic [31:0] wd);
        @(negedge clk);
        sw_op = op; sw_sel = sel; sw_idx = idx; sw_wdata = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        sw_op = OP_NOP;
    endtask

    task automatic wr(input logic sel, input logic [5:0] idx, input logic [31:0] wd);
        drive(OP_WR, sel, idx, wd);
        idle();
    endtask

    task automatic rd(input logic sel, input logic [5:0] idx, input logic [31:0] exp, input string req);
        item_t it;
        drive(OP_RD, sel, idx, '0);
        it.is_srch = 0; it.exp_rd = exp; it.exp_f = 0; it.exp_i = 0; it.req = req;
        exp_q.push_back(it);
        idle();
    endtask

    task automatic srch(input logic [31:0] va, input logic f, input logic [5:0] i, input string req);
        item_t it;
        drive(OP_SRCH, 1'b0, '0, va);
        it.is_srch = 1; it.exp_rd = 0; it.exp_f = f; it.exp_i = i; it.req = req;
        exp_q.push_back(it);
        idle();
    endtask

    task automatic lk(input logic [31:0] va, input logic hit, input logic multi, input logic [5:0] idx,
                      input logic [31:0] pa, input logic ex, input logic w,
                      input logic [3:0] zone, input logic [3:0] attr, input string req);
        lk_va = va;
        #1;
        check(lk_hit === hit, req, 32'(lk_hit), 32'(hit));
        check(lk_multi === multi, req, 32'(lk_multi), 32'(multi));
        if (hit) begin
            check(lk_idx === idx, req, 32'(lk_idx), 32'(idx));
            check(lk_pa === pa, req, lk_pa, pa);
            check({lk_exec, lk_wr, lk_zone, lk_attr} === {ex, w, zone, attr}, req,
                  32'({lk_exec, lk_wr, lk_zone, lk_attr}), 32'({ex, w, zone, attr}));
        end else begin
            check(lk_pa === 32'h0, req, lk_pa, 32'h0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(sw_rdata === 0 && sw_found === 0 && sw_fidx === 0, "R1", sw_rdata, 0);
        lk(32'h1234_5400, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        rd(1'b0, 6'd5, 32'h0, "R1");

        // entry 3: 1K page, low bits 5:0 of tag write dropped (R3)
        wr(1'b0, 6'd3, 32'h1234_547F);
        wr(1'b1, 6'd3, 32'h2AF3_7A5A);
        rd(1'b0, 6'd3, 32'h1234_5440, "R3");
        rd(1'b1, 6'd3, 32'h2AF3_7A5A, "R2");
        lk(32'h1234_54A7, 1, 0, 6'd3, 32'h2AF3_78A7, 1, 0, 4'h5, 4'hA, "R6");
        lk(32'h1234_5800, 0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // entry 20: 4K page with stored page bits inside the offset (R5)
        wr(1'b0, 6'd20, 32'h0000_3CC0);
        wr(1'b1, 6'd20, 32'h0007_7700);
        lk(32'h0000_3FFF, 1, 0, 6'd20, 32'h0007_7FFF, 1, 1, 4'h0, 4'h0, "R5");
        lk(32'h0000_3123, 1, 0, 6'd20, 32'h0007_7123, 1, 1, 4'h0, 4'h0, "R4");

        // entry 10: 16M page
        wr(1'b1, 6'd10, 32'h8000_0100);
        wr(1'b0, 6'd10, 32'h4000_03C0);
        lk(32'h40AB_CDEF, 1, 0, 6'd10, 32'h80AB_CDEF, 0, 1, 4'h0, 4'h0, "R4");
        lk(32'h4100_0000, 0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // entry 2: 1M page overlapping entry 10; lowest index wins (R7)
        wr(1'b1, 6'd2, 32'h0050_0000);
        wr(1'b0, 6'd2, 32'h4000_02C0);
        lk(32'h4001_2345, 1, 1, 6'd2, 32'h0051_2345, 0, 0, 4'h0, 4'h0, "R7");
        lk(32'h40AB_CDEF, 1, 0, 6'd10, 32'h80AB_CDEF, 0, 1, 4'h0, 4'h0, "R7");

        // search (R8)
        srch(32'h40AB_CDEF, 1, 6'd10, "R8");
        srch(32'h4001_2345, 1, 6'd2, "R8");
        srch(32'h0000_0007, 0, 6'd0, "R8");
        lk(32'h4001_2345, 1, 1, 6'd2, 32'h0051_2345, 0, 0, 4'h0, 4'h0, "R8");

        // R11: write visible only after its edge
        wr(1'b1, 6'd40, 32'h00C0_00F5);
        drive(OP_WR, 1'b0, 6'd40, 32'h0080_0140);
        lk(32'h0080_3ABC, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        idle();
        lk(32'h0080_3ABC, 1, 0, 6'd40, 32'h00C0_3ABC, 0, 0, 4'hF, 4'h5, "R11");

        // invalidate by address clears entries 2 and 10 only (R9)
        drive(OP_INV1, 1'b0, '0, 32'h4001_2345);
        idle();
        lk(32'h40AB_CDEF, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        lk(32'h4001_2345, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        lk(32'h0000_3123, 1, 0, 6'd20, 32'h0007_7123, 1, 1, 4'h0, 4'h0, "R9");
        rd(1'b0, 6'd10, 32'h4000_0380, "R9");

        // invalidate all (R10)
        drive(OP_INVA, 1'b0, '0, '0);
        idle();
        lk(32'h1234_5400, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        lk(32'h0080_3ABC, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        rd(1'b0, 6'd3, 32'h1234_5400, "R10");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule